// File: doc/BRIEF.md
# Asynchronous SRAM Request Sequencer

This block sits between a clocked system and an external asynchronous static RAM with an 18-bit address and a 16-bit data word. The system raises a request with a direction bit, an address and, for writes, a data word. On the clock edge where the request is taken, the controller latches these values. It then steps a small state machine that produces the memory strobes in an order with generous margins. Reads keep output enable low for two full cycles. Writes pulse write enable for one cycle, and the data driver stays on for one cycle after that pulse, so the word is still stable when write enable rises.

Read data is returned two ways. A raw copy follows the incoming data bus directly and is valid in the second read cycle. A registered copy is captured when the read finishes and holds until the next read finishes. The pad tri-state buffer sits outside the block. The controller supplies the outgoing word and an active-low drive enable for it.

The parameter `CHAIN` selects between two timings. By default every access passes through idle, so consecutive accesses start three cycles apart. With chaining on, the second cycle of an access can accept the next request, so consecutive accesses start two cycles apart.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the controller is idle, with ready = 1 and mem_oe_n, mem_we_n and mem_drv_n all 1.
- R2: A request is taken on a rising clock edge where req = 1 and ready = 1. rd_nwr = 1 means read and rd_nwr = 0 means write. req_addr is latched and appears on mem_addr for the whole access. For a write, wr_data is latched as well.
- R3: A read holds mem_oe_n low for exactly the two cycles after the accepting edge. mem_we_n and mem_drv_n stay high during those cycles, and ready is 0 in the first of them.
- R4: rdata_q loads the value on mem_dq_i at the edge that ends the second read cycle. It then keeps that value through writes and idle time until the next read ends.
- R5: rdata_raw always equals mem_dq_i, so it carries the stored word during the second read cycle.
- R6: In the first write cycle, mem_we_n = 0, mem_drv_n = 0, mem_oe_n = 1 and mem_dq_o equals the latched word. In the second write cycle, mem_we_n = 1 while mem_drv_n stays 0. Both are released when the write ends. mem_we_n is never low for two cycles in a row within one write.
- R7: With CHAIN = 0, ready is 0 in both access cycles. A request held high is therefore taken every third cycle.
- R8: A request presented while ready = 0 has no effect. The address, strobes and memory contents are unchanged by it.
- R9: With CHAIN = 1, ready is 1 in the second cycle of a read or write. A request taken there starts its first access cycle at the next edge, so chained accesses start two cycles apart. A read followed directly by a write shows mem_oe_n = 1 in the write's first cycle.
- R10: mem_oe_n and mem_drv_n are never both 0 in the same cycle.
- R11: mem_ce_n, mem_lb_n and mem_ub_n are always 0, so every access uses the full 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Word address of the request |
| wr_data | input | DW | Word to be written |
| rdata_q | output | DW | Registered read result |
| rdata_raw | output | DW | Unregistered copy of the incoming data bus |
| ready | output | 1 | Controller can take a request this cycle |
| mem_addr | output | AW | Address bus to the memory |
| mem_dq_o | output | DW | Outgoing word for the pad buffer |
| mem_dq_i | input | DW | Incoming value of the data bus |
| mem_drv_n | output | 1 | Pad buffer drive enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ce_n | output | 1 | Chip enable, tied active |
| mem_lb_n | output | 1 | Low byte enable, tied active |
| mem_ub_n | output | 1 | High byte enable, tied active |

## Verification
The access sequence is exercised with a table that mixes writes and reads. The table includes addresses with high bits set, a word of all ones and a word of all zeros, an overwrite of an earlier location, and a read of a location that was never written. These patterns show whether data reaches the memory on the rising edge of write enable and whether the registered result comes from the correct read. Separate directed tests cover three cases. A request held high through an access shows the three-cycle spacing. A write request offered mid-read is shown to be ignored. A chained read-write-read on a second instance with chaining enabled shows the two-cycle spacing and that the data driver never turns on while output enable is low.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter bit CHAIN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          rd_nwr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rdata_q,
  output logic [DW-1:0] rdata_raw,
  output logic          ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_drv_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ce_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n
);
  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_WR1, S_WR2} st_t;

  st_t           state, nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          take;

  assign ready = (state == S_IDLE) ||
                 (CHAIN && (state == S_RD2 || state == S_WR2));
  assign take  = ready && req;

  always_comb begin
    nxt = S_IDLE;
    case (state)
      S_RD1:   nxt = S_RD2;
      S_WR1:   nxt = S_WR2;
      default: nxt = S_IDLE;
    endcase
    if (take) nxt = rd_nwr ? S_RD1 : S_WR1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state <= nxt;
      if (take) addr_q <= req_addr;
      if (take && !rd_nwr) wdata_q <= wr_data;
      if (state == S_RD2) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rdata_raw = mem_dq_i;
  assign mem_oe_n  = !(state == S_RD1 || state == S_RD2);
  assign mem_we_n  = !(state == S_WR1);
  assign mem_drv_n = !(state == S_WR1 || state == S_WR2);
  assign mem_ce_n  = 1'b0;
  assign mem_lb_n  = 1'b0;
  assign mem_ub_n  = 1'b0;
endmodule

module sram_seq_ctrl_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          rd_nwr,
  input logic          ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_drv_n
);
  // R10
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_drv_n));

  // R6
  we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_drv_n);

  // R6
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && !rd_nwr) |=> (!mem_we_n && !mem_drv_n && mem_oe_n));

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> mem_we_n);

  // R3
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && rd_nwr) |=> (!mem_oe_n && mem_we_n && mem_drv_n && !ready));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(mem_addr));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .ready(ready),
  .mem_addr(mem_addr), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_drv_n(mem_drv_n)
);

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // default instance
  logic req = 0, rd_nwr = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rdata_q, rdata_raw, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;
  logic ready, mem_drv_n, mem_we_n, mem_oe_n, mem_ce_n, mem_lb_n, mem_ub_n;
  logic [15:0] ram [256];
  logic [15:0] exp_mem [256];

  sram_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .req_addr(req_addr),
    .wr_data(wr_data), .rdata_q(rdata_q), .rdata_raw(rdata_raw), .ready(ready),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_drv_n(mem_drv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ce_n(mem_ce_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n));

  assign mem_dq_i = !mem_oe_n ? ram[mem_addr[7:0]] : 16'hFFFF;
  always @(posedge mem_we_n) if (mem_drv_n === 1'b0) ram[mem_addr[7:0]] <= mem_dq_o;

  // chained instance
  logic c_req = 0, c_rd = 0;
  logic [17:0] c_addr_in = '0;
  logic [15:0] c_wdat = '0;
  logic [15:0] c_rdata_q, c_raw, c_dq_o, c_dq_i;
  logic [17:0] c_addr;
  logic c_ready, c_drv_n, c_we_n, c_oe_n, c_ce_n, c_lb_n, c_ub_n;
  logic [15:0] c_ram [256];

  sram_seq_ctrl #(.CHAIN(1'b1)) dut_ch (
    .clk(clk), .rst_n(rst_n), .req(c_req), .rd_nwr(c_rd), .req_addr(c_addr_in),
    .wr_data(c_wdat), .rdata_q(c_rdata_q), .rdata_raw(c_raw), .ready(c_ready),
    .mem_addr(c_addr), .mem_dq_o(c_dq_o), .mem_dq_i(c_dq_i),
    .mem_drv_n(c_drv_n), .mem_we_n(c_we_n), .mem_oe_n(c_oe_n),
    .mem_ce_n(c_ce_n), .mem_lb_n(c_lb_n), .mem_ub_n(c_ub_n));

  assign c_dq_i = !c_oe_n ? c_ram[c_addr[7:0]] : 16'hFFFF;
  always @(posedge c_we_n) if (c_drv_n === 1'b0) c_ram[c_addr[7:0]] <= c_dq_o;

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 16'(i * 16'h0101 + 16'h1000);
      c_ram[i] = 16'(i * 16'h0101 + 16'h1000);
      exp_mem[i] = 16'(i * 16'h0101 + 16'h1000);
    end
  end

  // {rd_nwr, addr, data}
  localparam logic [34:0] VEC [9] = '{
    {1'b0, 18'h00010, 16'hA5A5},
    {1'b0, 18'h3FF22, 16'h5A5A},
    {1'b1, 18'h00010, 16'h0000},
    {1'b1, 18'h3FF22, 16'h0000},
    {1'b0, 18'h00033, 16'hFFFF},
    {1'b1, 18'h00033, 16'h0000},
    {1'b0, 18'h00010, 16'h0000},
    {1'b1, 18'h00010, 16'h0000},
    {1'b1, 18'h00044, 16'h0000}
  };

  logic [15:0] last_rd = '0;

  task automatic op(input logic rw, input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; rd_nwr = rw; req_addr = a; wr_data = d;
    @(negedge clk);
    req = 0;
    chk(mem_addr == a, "R2 address", 32'(mem_addr), 32'(a));
    if (rw) begin
      chk(!mem_oe_n && mem_we_n && mem_drv_n && !ready, "R3 read cycle 1",
          {mem_oe_n, mem_we_n, mem_drv_n, ready}, 32'b0110);
    end else begin
      chk(!mem_we_n && !mem_drv_n && mem_oe_n && !ready, "R6 write cycle 1",
          {mem_oe_n, mem_we_n, mem_drv_n, ready}, 32'b1000);
      chk(mem_dq_o == d, "R6 write data", 32'(mem_dq_o), 32'(d));
    end
    @(negedge clk);
    if (rw) begin
      chk(!mem_oe_n && !ready, "R3 R7 read cycle 2", {mem_oe_n, ready}, 32'b00);
      chk(rdata_raw == exp_mem[a[7:0]], "R5 raw data", 32'(rdata_raw), 32'(exp_mem[a[7:0]]));
    end else begin
      chk(mem_we_n && !mem_drv_n && !ready, "R6 R7 write cycle 2",
          {mem_we_n, mem_drv_n, ready}, 32'b100);
      exp_mem[a[7:0]] = d;
    end
    @(negedge clk);
    chk(ready && mem_oe_n && mem_we_n && mem_drv_n, "R6 released in idle",
        {ready, mem_oe_n, mem_we_n, mem_drv_n}, 32'b1111);
    chk({mem_ce_n, mem_lb_n, mem_ub_n} == 3'b000, "R11 enables",
        32'({mem_ce_n, mem_lb_n, mem_ub_n}), 32'b0);
    if (rw) last_rd = exp_mem[a[7:0]];
    chk(rdata_q == last_rd, "R4 registered result", 32'(rdata_q), 32'(last_rd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && mem_oe_n && mem_we_n && mem_drv_n, "R1 in reset",
        {ready, mem_oe_n, mem_we_n, mem_drv_n}, 32'b1111);
    rst_n = 1;
    @(negedge clk);
    chk(ready && mem_oe_n && mem_we_n && mem_drv_n && rdata_q == 0, "R1 after reset",
        {ready, mem_oe_n, mem_we_n, mem_drv_n}, 32'b1111);

    foreach (VEC[i]) op(VEC[i][34], VEC[i][33:16], VEC[i][15:0]);

    // R7: request held high is taken every third cycle
    @(negedge clk);
    req = 1; rd_nwr = 1; req_addr = 18'h00033;
    @(negedge clk); chk(!mem_oe_n, "R7 held req cycle 1", 32'(mem_oe_n), 0);
    @(negedge clk); chk(!mem_oe_n && !ready, "R7 held req cycle 2", {mem_oe_n, ready}, 0);
    @(negedge clk); chk(mem_oe_n && ready, "R7 held req idle gap", {mem_oe_n, ready}, 32'b11);
    @(negedge clk); chk(!mem_oe_n, "R7 held req next access", 32'(mem_oe_n), 0);
    req = 0;
    repeat (2) @(negedge clk);

    // R8: write offered mid-read is ignored
    req = 1; rd_nwr = 1; req_addr = 18'h00055;
    @(negedge clk);
    rd_nwr = 0; req_addr = 18'h00066; wr_data = 16'hDEAD;
    @(negedge clk);
    chk(mem_addr == 18'h00055 && mem_we_n && mem_drv_n, "R8 busy request ignored",
        32'(mem_addr), 32'h55);
    req = 0;
    @(negedge clk);
    chk(mem_we_n && mem_drv_n && ready, "R8 no write started", {mem_we_n, mem_drv_n, ready}, 32'b111);
    last_rd = exp_mem[8'h55];
    op(1'b1, 18'h00066, 16'h0000);

    // R9: chained read A, write B, read B
    @(negedge clk);
    c_req = 1; c_rd = 1; c_addr_in = 18'h00070;
    @(negedge clk);
    chk(!c_ready && !c_oe_n, "R9 chain read cycle 1", {c_ready, c_oe_n}, 0);
    c_rd = 0; c_addr_in = 18'h00071; c_wdat = 16'h3C3C;
    @(negedge clk);
    chk(c_ready && !c_oe_n, "R9 ready in read cycle 2", {c_ready, c_oe_n}, 32'b10);
    @(negedge clk);
    chk(c_oe_n && !c_we_n && !c_drv_n, "R9 R10 read to write turn", {c_oe_n, c_we_n, c_drv_n}, 32'b100);
    chk(c_dq_o == 16'h3C3C && c_addr == 18'h00071, "R9 chained write", 32'(c_dq_o), 32'h3C3C);
    chk(c_rdata_q == 16'(8'h70 * 16'h0101 + 16'h1000), "R4 chained read capture",
        32'(c_rdata_q), 32'(16'(8'h70 * 16'h0101 + 16'h1000)));
    c_rd = 1;
    @(negedge clk);
    chk(c_we_n && !c_drv_n && c_ready, "R9 write cycle 2 ready", {c_we_n, c_drv_n, c_ready}, 32'b101);
    @(negedge clk);
    chk(!c_oe_n && c_drv_n && c_addr == 18'h00071, "R9 chained read start", {c_oe_n, c_drv_n}, 32'b01);
    c_req = 0;
    @(negedge clk);
    chk(c_raw == 16'h3C3C, "R5 chained raw", 32'(c_raw), 32'h3C3C);
    @(negedge clk);
    chk(c_rdata_q == 16'h3C3C && c_ready && c_oe_n, "R9 chained result", 32'(c_rdata_q), 32'h3C3C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule